// File: doc/BRIEF.md
# Pipeline Sub-Code Aligner

A pipelined converter is a chain of stages, each resolving a few bits of the input. A sample passes down the chain one stage per clock, so its sub-codes come out of the stages on successive cycles. The first stage produces its code first and the last stage produces its code last. This block receives those codes. For each stage it keeps a delay line whose depth falls as the stage index rises, so that all the codes of one sample arrive in the same cycle. It then merges them into one output word.

Two merge variants are available through a parameter. In join mode the codes are placed side by side, with the first stage at the most significant end. In overlap mode every stage except the last carries one redundant bit. Each code is shifted so that it overlaps its neighbour by one bit, the shifted codes are added, and the sum is clamped at full scale. Once the delay lines have filled, a valid flag rises and a new word leaves the block on every clock.

Top module: `subcode_aligner`

## Requirements
- R1: While `rst_n` is low, `word` reads all zeros and `word_valid` reads 0. Assertion of `rst_n` takes effect without waiting for a clock edge.
- R2: After reset is released, `word_valid` stays low for the first NSTG-1 rising edges and goes high at edge NSTG.
- R3: Once `word_valid` is high, it stays high until the next reset.
- R4: The code of stage j (stages counted 1..NSTG) for a given sample is presented j-1 cycles after the code of stage 1 for that sample. The merged word for that sample becomes visible after NSTG rising edges, counted from the edge that captured its stage-1 code.
- R5: In join mode the word is SUM(Bj) bits wide. Each stage's field takes the same bit positions as on `sub_codes`. Stage 1 sits at the top, and the fields follow in stage order down to the last stage at bit 0. With the default widths 3, 3, 2, stage 1 is bits [7:5], stage 2 is bits [4:2] and stage 3 is bits [1:0].
- R6: Consecutive samples give words on consecutive cycles, in sample order, with no gaps and no extra words.
- R7: In overlap mode the word is SUM(Bj)-(NSTG-1) bits wide. Each word is the sum of code_j shifted left by o_j, where o_NSTG = 0 and o_j = o_(j+1) + B_(j+1) - 1. For the defaults this gives 6 bits and the value 8*c1 + 2*c2 + c3.
- R8: In overlap mode, a sum above 2^W-1 (W being the word width) reads as 2^W-1. A sum equal to 2^W-1 passes unchanged.
- R9: A reset asserted in the middle of a stream discards every partly aligned sample. After release, the fill sequence of R2 starts again, and the first word is the first sample presented after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously to `clk` |
| sub_codes | input | SUM(Bj) | All stage codes in one bus; stage 1 in the top field, last stage at bit 0 |
| word | output | SUM(Bj) in join mode, SUM(Bj)-(NSTG-1) in overlap mode | Merged output word |
| word_valid | output | 1 | High once every delay line holds post-reset data |

## Verification
The bench streams skewed samples and pairs each word with the sample that produced it. A lane with one register too many or too few shows up at once as a word that mixes fields from neighbouring samples. Streams of all-maximum codes and a pair of values on either side of full scale exercise the overlap clamp. A missing clamp wraps to a small value, and an off-by-one clamp corrupts the exact full-scale case. The fill window is checked edge by edge and repeated after a reset in mid-stream. A flag that rose one edge early would let a reset-zero word through, and a delay line that kept its contents through reset would put stale fields into the first words.

// File: rtl/sca_pkg.sv
package sca_pkg;

  localparam int unsigned SCA_MAX_STG = 8;

  typedef int unsigned wlist_t [SCA_MAX_STG];

  typedef enum logic {
    CMB_JOIN    = 1'b0,
    CMB_OVERLAP = 1'b1
  } combine_mode_e;

  // total width of the first n stage codes
  function automatic int unsigned sum_w(wlist_t w, int unsigned n);
    int unsigned s;
    s = 0;
    for (int unsigned i = 0; i < SCA_MAX_STG; i++)
      if (i < n) s += w[i];
    return s;
  endfunction

  // width of all stages after stage index j (0-based): bus position of stage j
  function automatic int unsigned tail_w(wlist_t w, int unsigned n, int unsigned j);
    int unsigned s;
    s = 0;
    for (int unsigned i = 0; i < SCA_MAX_STG; i++)
      if (i > j && i < n) s += w[i];
    return s;
  endfunction

  function automatic int unsigned out_w(wlist_t w, int unsigned n, combine_mode_e m);
    return (m == CMB_OVERLAP) ? sum_w(w, n) - (n - 1) : sum_w(w, n);
  endfunction

  // weight shift of stage j inside the merged word
  function automatic int unsigned merge_lo(wlist_t w, int unsigned n, int unsigned j,
                                           combine_mode_e m);
    return (m == CMB_OVERLAP) ? tail_w(w, n, j) - (n - 1 - j) : tail_w(w, n, j);
  endfunction

endpackage

// File: rtl/sca_delay_line.sv
module sca_delay_line #(
  parameter int unsigned W     = 2,
  parameter int unsigned DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] pipe_d [DEPTH];
  logic [W-1:0] pipe_q [DEPTH];

  always_comb begin
    pipe_d[0] = din;
    for (int unsigned i = 1; i < DEPTH; i++) pipe_d[i] = pipe_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int unsigned i = 0; i < DEPTH; i++) pipe_q[i] <= '0;
    end else begin
      for (int unsigned i = 0; i < DEPTH; i++) pipe_q[i] <= pipe_d[i];
    end
  end

  assign dout = pipe_q[DEPTH-1];

endmodule

// File: rtl/sca_fill_tracker.sv
module sca_fill_tracker #(
  parameter int unsigned NSTG = 3,
  localparam int unsigned CW  = $clog2(NSTG + 1)
) (
  input  logic clk,
  input  logic rst_n,
  output logic full
);

  logic [CW-1:0] cnt_d, cnt_q;

  always_comb begin
    if (cnt_q == CW'(NSTG)) cnt_d = cnt_q;
    else                    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign full = (cnt_q == CW'(NSTG));

endmodule

// File: rtl/sca_merge.sv
module sca_merge
  import sca_pkg::*;
#(
  parameter int unsigned   NSTG  = 3,
  parameter wlist_t        SUB_W = '{3, 3, 2, 0, 0, 0, 0, 0},
  parameter combine_mode_e MODE  = CMB_JOIN,
  localparam int unsigned  IN_W  = sum_w(SUB_W, NSTG),
  localparam int unsigned  OUT_W = out_w(SUB_W, NSTG, MODE),
  localparam int unsigned  ACC_W = OUT_W + $clog2(NSTG) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IN_W-1:0]  aligned,
  output logic [OUT_W-1:0] word_q
);

  logic [ACC_W-1:0] term [NSTG];
  logic [ACC_W-1:0] acc;
  logic [OUT_W-1:0] word_d;

  for (genvar j = 0; j < NSTG; j++) begin : g_term
    localparam int unsigned WJ  = SUB_W[j];
    localparam int unsigned ILO = tail_w(SUB_W, NSTG, j);
    localparam int unsigned OLO = merge_lo(SUB_W, NSTG, j, MODE);
    assign term[j] = ACC_W'(aligned[ILO +: WJ]) << OLO;
  end

  always_comb begin
    acc = '0;
    for (int unsigned j = 0; j < NSTG; j++) begin
      if (MODE == CMB_OVERLAP) acc = acc + term[j];
      else                     acc = acc | term[j];
    end
    if ((acc >> OUT_W) != '0) word_d = '1;
    else                      word_d = acc[OUT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

endmodule

// File: rtl/subcode_aligner.sv
module subcode_aligner
  import sca_pkg::*;
#(
  parameter int unsigned   NSTG  = 3,
  parameter wlist_t        SUB_W = '{3, 3, 2, 0, 0, 0, 0, 0},
  parameter combine_mode_e MODE  = CMB_JOIN,
  localparam int unsigned  IN_W  = sum_w(SUB_W, NSTG),
  localparam int unsigned  OUT_W = out_w(SUB_W, NSTG, MODE)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IN_W-1:0]  sub_codes,
  output logic [OUT_W-1:0] word,
  output logic             word_valid
);

  logic [IN_W-1:0] aligned;

  // stage j waits NSTG-1-j cycles in its lane; the shared output register adds one more
  for (genvar j = 0; j < NSTG; j++) begin : g_lane
    localparam int unsigned WJ = SUB_W[j];
    localparam int unsigned LO = tail_w(SUB_W, NSTG, j);
    if (j < NSTG - 1) begin : g_dly
      sca_delay_line #(
        .W     (WJ),
        .DEPTH (NSTG - 1 - j)
      ) u_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (sub_codes[LO +: WJ]),
        .dout  (aligned[LO +: WJ])
      );
    end else begin : g_last
      assign aligned[LO +: WJ] = sub_codes[LO +: WJ];
    end
  end

  sca_merge #(
    .NSTG  (NSTG),
    .SUB_W (SUB_W),
    .MODE  (MODE)
  ) u_merge (
    .clk     (clk),
    .rst_n   (rst_n),
    .aligned (aligned),
    .word_q  (word)
  );

  sca_fill_tracker #(
    .NSTG (NSTG)
  ) u_fill (
    .clk   (clk),
    .rst_n (rst_n),
    .full  (word_valid)
  );

endmodule

// File: rtl/sca_chk.sv
module sca_chk
  import sca_pkg::*;
#(
  parameter int unsigned   NSTG  = 3,
  parameter wlist_t        SUB_W = '{3, 3, 2, 0, 0, 0, 0, 0},
  parameter combine_mode_e MODE  = CMB_JOIN,
  localparam int unsigned  IN_W  = sum_w(SUB_W, NSTG),
  localparam int unsigned  OUT_W = out_w(SUB_W, NSTG, MODE),
  localparam int unsigned  CW    = $clog2(NSTG + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [IN_W-1:0]  sub_codes,
  input logic [OUT_W-1:0] word,
  input logic             word_valid
);

  logic [CW-1:0] edges_d, edges_q;

  always_comb begin
    if (edges_q == CW'(NSTG)) edges_d = edges_q;
    else                      edges_d = edges_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) edges_q <= '0;
    else        edges_q <= edges_d;
  end

  // R2
  fill_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edges_q < CW'(NSTG)) |-> !word_valid);

  // R2
  fill_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edges_q == CW'(NSTG)) |-> word_valid);

  // R3
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> word_valid);

  if (MODE == CMB_JOIN) begin : g_join
    for (genvar j = 0; j < NSTG; j++) begin : g_fld
      localparam int unsigned WJ = SUB_W[j];
      localparam int unsigned LO = tail_w(SUB_W, NSTG, j);
      // R4 R5
      field_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> (word[LO +: WJ] == $past(sub_codes[LO +: WJ], NSTG - j)));
    end
  end

endmodule

bind subcode_aligner sca_chk #(
  .NSTG  (NSTG),
  .SUB_W (SUB_W),
  .MODE  (MODE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sub_codes  (sub_codes),
  .word       (word),
  .word_valid (word_valid)
);

// File: tb/tb_subcode_aligner.sv
module tb_subcode_aligner;

  localparam int NSTG = 3;

  logic       clk;
  logic       rst_n;
  logic [7:0] sub_codes;
  logic [7:0] word_j;
  logic       vld_j;
  logic [5:0] word_o;
  logic       vld_o;

  int  n_chk;
  int  n_fail;
  bit  mon_en;
  bit  seen_vld;
  bit  done;
  logic [7:0] exp_q [$];

  subcode_aligner #(
    .NSTG  (NSTG),
    .SUB_W ('{3, 3, 2, 0, 0, 0, 0, 0}),
    .MODE  (sca_pkg::CMB_JOIN)
  ) dut (
    .clk (clk), .rst_n (rst_n), .sub_codes (sub_codes),
    .word (word_j), .word_valid (vld_j)
  );

  subcode_aligner #(
    .NSTG  (NSTG),
    .SUB_W ('{3, 3, 2, 0, 0, 0, 0, 0}),
    .MODE  (sca_pkg::CMB_OVERLAP)
  ) dut_ovl (
    .clk (clk), .rst_n (rst_n), .sub_codes (sub_codes),
    .word (word_o), .word_valid (vld_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  function automatic int ovl_value(logic [7:0] s);
    int v;
    v = int'(s[7:5]) * 8 + int'(s[4:2]) * 2 + int'(s[1:0]);
    return (v > 63) ? 63 : v;
  endfunction

  function automatic logic [7:0] make_sample(int pat, int i);
    case (pat)
      0:       return 8'h00;
      1:       return 8'hFF;
      2:       return 8'(i * 37 + 5);
      3:       return (i % 2 == 1) ? 8'hED : 8'hEE;  // 63 exact / 64 clamped
      default: return 8'($urandom);
    endcase
  endfunction

  // monitor: pops one expected sample per valid word
  always @(negedge clk) begin
    if (mon_en) begin
      if (vld_j) begin
        seen_vld = 1'b1;
        chk(vld_o == 1'b1, "R2 overlap valid matches", int'(vld_o), 1);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6 word with no pending sample", int'(word_j), -1);
        end else begin
          logic [7:0] e;
          int ov;
          e  = exp_q.pop_front();
          ov = int'(e[7:5]) * 8 + int'(e[4:2]) * 2 + int'(e[1:0]);
          chk(word_j == e, "R4 R5 join word", int'(word_j), int'(e));
          if (ov > 63) chk(int'(word_o) == ovl_value(e), "R8 clamp", int'(word_o), ovl_value(e));
          else         chk(int'(word_o) == ovl_value(e), "R7 overlap sum", int'(word_o), ovl_value(e));
        end
      end else if (seen_vld) begin
        chk(1'b0, "R3 valid dropped", 0, 1);
      end
    end
  end

  task automatic reset_dut();
    mon_en = 1'b0;
    rst_n  = 1'b0;
    exp_q.delete();
    repeat (2) @(posedge clk);
    #1;
    chk(word_j == 8'd0 && vld_j == 1'b0, "R1 join reset state", int'(word_j) + int'(vld_j), 0);
    chk(word_o == 6'd0 && vld_o == 1'b0, "R1 overlap reset state", int'(word_o) + int'(vld_o), 0);
    @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  // driver: called 1 time unit after the edge that releases reset
  task automatic stream(input int n, input int pat, input bit abort, input string ftag);
    logic [7:0] s [256];
    for (int i = 0; i < n; i++) s[i] = make_sample(pat, i);
    seen_vld = 1'b0;
    mon_en   = 1'b1;
    for (int c = 0; c < n + NSTG - 1; c++) begin
      logic [2:0] a;
      logic [2:0] b;
      logic [1:0] d;
      if (abort && c == n / 2) begin
        mon_en = 1'b0;
        rst_n  = 1'b0;
        #1;
        chk(word_j == 8'd0 && vld_j == 1'b0, "R9 mid-stream reset clears join", int'(word_j), 0);
        chk(word_o == 6'd0 && vld_o == 1'b0, "R9 mid-stream reset clears overlap", int'(word_o), 0);
        exp_q.delete();
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        return;
      end
      a = (c < n) ? s[c][7:5] : 3'd0;
      b = (c >= 1 && c - 1 < n) ? s[c-1][4:2] : 3'd0;
      d = (c >= 2 && c - 2 < n) ? s[c-2][1:0] : 2'd0;
      if (c < n) exp_q.push_back(s[c]);
      sub_codes = {a, b, d};
      if (c <= NSTG) begin
        chk(vld_j == (c >= NSTG), ftag, int'(vld_j), int'(c >= NSTG));
        chk(vld_o == (c >= NSTG), ftag, int'(vld_o), int'(c >= NSTG));
      end
      @(posedge clk);
      #1;
    end
    @(posedge clk);
    #1 mon_en = 1'b0;
    chk(exp_q.size() == 0, "R6 every sample produced a word", exp_q.size(), 0);
  endtask

  initial begin
    n_chk     = 0;
    n_fail    = 0;
    mon_en    = 1'b0;
    seen_vld  = 1'b0;
    done      = 1'b0;
    rst_n     = 1'b0;
    sub_codes = 8'd0;

    reset_dut(); stream(12, 0, 1'b0, "R2 fill window");
    reset_dut(); stream(12, 1, 1'b0, "R2 fill window");
    reset_dut(); stream(40, 2, 1'b0, "R2 fill window");
    reset_dut(); stream(16, 3, 1'b0, "R2 fill window");
    reset_dut(); stream(30, 4, 1'b1, "R2 fill window");
    stream(50, 4, 1'b0, "R9 refill after mid-stream reset");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R6 watchdog expired: actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule